// File: doc/BRIEF.md
# CAN Node Fault Confinement Controller

This block keeps the error standing of one CAN node. It holds a transmit error tally and a receive error tally and uses them to place the node in one of three fault states: error-active, error-passive or bus-off. The protocol engine feeds it single-cycle event strobes: transmit error, receive error, acknowledge error, good transmission and good reception. It also feeds the sampled bus level with a strobe that marks each bit time. The block does not detect errors and does not time bits. It only turns the reported events into counts and a state.

The outputs are the two tallies, a 2-bit state code, a one-cycle interrupt pulse on entry to bus-off, and a level that tells the transmitter to hold off its start while the node is error-passive. The node leaves bus-off only after the bus has shown 128 runs of 11 consecutive recessive bits. A hidden run counter steps the reused transmit tally once for each completed run. Every register updates on the same rising edge that samples the strobes, so each output reflects a strobe one cycle after it is presented.

Top module: `can_fault_conf`

## Requirements
- R1: A low level on `rst_n` at a rising clock edge clears both tallies and the hidden run counter, forces the error-active state (`state_o` = 2'b00) and drops `busoff_irq_o`.
- R2: Outside bus-off, a transmit error adds 8 to the transmit tally. An acknowledge error adds 8 only while error-active. A good transmission subtracts 1, but the tally never goes below 0. When an error and a good transmission arrive in the same cycle, the error wins and the good transmission is dropped.
- R3: Outside bus-off, a receive error adds 1 to the receive tally unless the tally already exceeds 127, so the tally never exceeds 128. A good reception subtracts 1, with a floor of 0. When both arrive in the same cycle, the error wins.
- R4: A good reception while the receive tally is above 127 loads the tally with 119.
- R5: When either tally reaches 128 or more, the error-active state moves to error-passive (`state_o` = 2'b01). `tx_delay_o` is high exactly while the node is error-passive.
- R6: The error-passive state returns to error-active in the cycle where both tallies become 127 or less.
- R7: An acknowledge error while error-passive leaves the transmit tally unchanged. As a result, a node that sees only acknowledge errors settles at 128 in error-passive and never reaches bus-off.
- R8: If a transmit error would push the transmit tally above 255, the node enters bus-off (`state_o` = 2'b10) and the transmit tally becomes 0. `busoff_irq_o` is high for exactly that one cycle, and the receive tally keeps its value.
- R9: In bus-off, each bit-time strobe with `bit_val_i` = 1 (recessive) extends a hidden run. The 11th consecutive recessive bit closes the run and adds 1 to the transmit tally. A strobe with `bit_val_i` = 0 (dominant) restarts the run without touching the tally.
- R10: When the transmit tally reaches 128 in bus-off, the node returns to error-active and both tallies become 0.
- R11: In bus-off, the error, acknowledge and success strobes have no effect on either tally or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Good transmission strobe |
| rx_ok_i | input | 1 | Good reception strobe |
| ack_err_i | input | 1 | Acknowledge error strobe (raised as transmitter) |
| bit_tick_i | input | 1 | One pulse per bus bit time |
| bit_val_i | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| tec_o | output | 8 | Transmit error tally |
| rec_o | output | 8 | Receive error tally |
| state_o | output | 2 | Fault state: 00 active, 01 passive, 10 bus-off |
| busoff_irq_o | output | 1 | One-cycle pulse on entry to bus-off |
| tx_delay_o | output | 1 | Hold off transmit start (error-passive) |

## Verification
The embedded assertions check on every cycle that both tallies stay below 128 while error-active and that the receive tally never passes 128. They also check that the bus-off interrupt is a single-cycle pulse that coincides with a cleared transmit tally, that the hidden run never reaches 11, that a bus-off exit always shows two zeroed tallies, and that passive acknowledge errors and bus-off strobes leave the tallies alone. Only the bench scenarios can show the exact arithmetic of the weights and floors, the reload to 119, and the full 128-run recovery sequence. The same holds for the restart of a run after a dominant bit and the lone-node case that settles at 128 without reaching bus-off.

// File: rtl/can_fc_pkg.sv
// Package: shared fault-state encoding for the fault confinement block.
// Assumes bus-off needs only the upper bit; the lower bit is zero there.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/can_fc_txcnt.sv
// Module: transmit error tally.
// Works out the unclipped next value (one extra bit, so an overflow is
// visible) from a weighted error add, a unit add used in recovery and a
// floored unit subtract. The caller's clear overrides the step.
// Assumes at most one of add_err / add_one is meaningful in a cycle.
module can_fc_txcnt #(
    parameter int W          = 8,
    parameter int ERR_WEIGHT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_err,
    input  logic         add_one,
    input  logic         sub_ok,
    input  logic         clr,
    output logic [W-1:0] cnt_q,
    output logic [W:0]   cnt_raw
);
    localparam logic [W:0] WEIGHT_W = (W+1)'(ERR_WEIGHT);

    // Next value before clipping: error add beats recovery add beats subtract.
    always_comb begin
        cnt_raw = {1'b0, cnt_q};
        if (add_err) begin
            cnt_raw = {1'b0, cnt_q} + WEIGHT_W;
        end else if (add_one) begin
            cnt_raw = {1'b0, cnt_q} + (W+1)'(1);
        end else if (sub_ok && (cnt_q != '0)) begin
            cnt_raw = {1'b0, cnt_q} - (W+1)'(1);
        end
    end

    // Tally register with synchronous active-low reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_raw[W-1:0];
        end
    end

    // R2: without a weighted error the tally moves by at most one.
    a_r2_small_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_err && !clr) |=> ({1'b0, cnt_q} <= {1'b0, $past(cnt_q)} + (W+1)'(1)));

    // R2: a subtract at zero leaves zero.
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_ok && !add_err && !add_one && !clr && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/can_fc_rxcnt.sv
// Module: receive error tally.
// Saturates one step past the passive threshold and reloads a fixed value
// on a good reception from above the threshold. Holds while 'hold' is high.
module can_fc_rxcnt #(
    parameter int W          = 8,
    parameter int PASSIVE_TH = 128,
    parameter int RELOAD     = 119
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_err,
    input  logic         sub_ok,
    input  logic         hold,
    input  logic         clr,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] TH_W     = W'(PASSIVE_TH);
    localparam logic [W-1:0] RELOAD_W = W'(RELOAD);

    // Next value: error (saturating) beats success (reload or floored decrement).
    always_comb begin
        cnt_nxt = cnt_q;
        if (!hold) begin
            if (add_err) begin
                if (cnt_q < TH_W) cnt_nxt = cnt_q + W'(1);
            end else if (sub_ok) begin
                if (cnt_q >= TH_W)      cnt_nxt = RELOAD_W;
                else if (cnt_q != '0)   cnt_nxt = cnt_q - W'(1);
            end
        end
    end

    // Tally register with synchronous active-low reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R3: the tally never passes the threshold value.
    a_r3_rec_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TH_W);

    // R4: good reception above the threshold reloads the fixed value.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_ok && !add_err && !hold && !clr && cnt_q >= TH_W) |=> (cnt_q == RELOAD_W));
endmodule

// File: rtl/can_fc_recov.sv
// Module: hidden recessive-run counter used during bus-off.
// Counts consecutive recessive bit times, wraps after RUN_LEN and flags
// the completed run for one cycle. Idles at zero while disabled.
module can_fc_recov #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic bit_rec,
    output logic run_done
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    // Flag a run when the final recessive bit of the run arrives.
    assign run_done = enable && bit_tick && bit_rec && (run_q == LAST);

    // Run counter: dominant restarts, last bit wraps, idle while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q <= '0;
        end else if (bit_tick) begin
            if (!bit_rec || run_q == LAST) run_q <= '0;
            else                           run_q <= run_q + CW'(1);
        end
    end

    // R9: the run counter stays inside one run.
    a_r9_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST);

    // R9: a dominant bit restarts the run.
    a_r9_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !bit_rec) |=> (run_q == '0));
endmodule

// File: rtl/can_fc_state.sv
// Module: fault state machine.
// Decides state moves from the unclipped next tally values and the
// recovery run flag; issues tally clears and the bus-off pulse.
// Assumes the tally modules expose next values without clears applied.
module can_fc_state
    import can_fc_pkg::*;
#(
    parameter int W            = 8,
    parameter int PASSIVE_TH   = 128,
    parameter int RECOV_TARGET = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tec_q,
    input  logic [W:0]   tec_raw,
    input  logic [W-1:0] rec_nxt,
    input  logic         run_done,
    output fc_state_e    state_q,
    output logic         tec_clr,
    output logic         rec_clr,
    output logic         irq_q
);
    localparam logic [W:0]   TH_TX  = (W+1)'(PASSIVE_TH);
    localparam logic [W-1:0] TH_RX  = W'(PASSIVE_TH);
    localparam logic [W-1:0] RC_END = W'(RECOV_TARGET - 1);

    fc_state_e state_d;
    logic      irq_d;

    // Next-state and clear decisions for each fault state.
    always_comb begin
        state_d = state_q;
        tec_clr = 1'b0;
        rec_clr = 1'b0;
        irq_d   = 1'b0;
        case (state_q)
            FC_ACTIVE: begin
                if (tec_raw >= TH_TX || rec_nxt >= TH_RX) state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (tec_raw[W]) begin
                    state_d = FC_BUSOFF;
                    tec_clr = 1'b1;
                    irq_d   = 1'b1;
                end else if (tec_raw < TH_TX && rec_nxt < TH_RX) begin
                    state_d = FC_ACTIVE;
                end
            end
            FC_BUSOFF: begin
                if (run_done && tec_q == RC_END) begin
                    state_d = FC_ACTIVE;
                    tec_clr = 1'b1;
                    rec_clr = 1'b1;
                end
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    // State and interrupt registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // R8: the interrupt is only seen together with the bus-off state.
    a_r8_irq_in_busoff: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (state_q == FC_BUSOFF));
endmodule

// File: rtl/can_fault_conf.sv
// Module: CAN fault confinement top.
// Gates the protocol strobes by fault state, feeds the two tallies and the
// recovery run counter, and drives the state machine. Assumes strobes are
// single-cycle and synchronous to clk.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int PASSIVE_TH   = 128,
    parameter int TX_WEIGHT    = 8,
    parameter int RX_RELOAD    = 119,
    parameter int RUN_LEN      = 11,
    parameter int RECOV_TARGET = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             ack_err_i,
    input  logic             bit_tick_i,
    input  logic             bit_val_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             busoff_irq_o,
    output logic             tx_delay_o
);
    localparam logic [CNT_W-1:0] TH_W = CNT_W'(PASSIVE_TH);

    fc_state_e        st;
    logic             in_active, in_busoff;
    logic             tx_add, tx_sub, run_done;
    logic             tec_clr, rec_clr, irq;
    logic [CNT_W-1:0] tec_q, rec_q, rec_nxt;
    logic [CNT_W:0]   tec_raw;

    // Strobe gating: acknowledge errors count only while error-active.
    assign in_active = (st == FC_ACTIVE);
    assign in_busoff = (st == FC_BUSOFF);
    assign tx_add    = !in_busoff && (tx_err_i || (ack_err_i && in_active));
    assign tx_sub    = !in_busoff && tx_ok_i;

    can_fc_txcnt #(.W(CNT_W), .ERR_WEIGHT(TX_WEIGHT)) u_tx (
        .clk(clk), .rst_n(rst_n), .add_err(tx_add), .add_one(run_done),
        .sub_ok(tx_sub), .clr(tec_clr), .cnt_q(tec_q), .cnt_raw(tec_raw)
    );

    can_fc_rxcnt #(.W(CNT_W), .PASSIVE_TH(PASSIVE_TH), .RELOAD(RX_RELOAD)) u_rx (
        .clk(clk), .rst_n(rst_n), .add_err(rx_err_i), .sub_ok(rx_ok_i),
        .hold(in_busoff), .clr(rec_clr), .cnt_q(rec_q), .cnt_nxt(rec_nxt)
    );

    can_fc_recov #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .enable(in_busoff), .bit_tick(bit_tick_i),
        .bit_rec(bit_val_i), .run_done(run_done)
    );

    can_fc_state #(.W(CNT_W), .PASSIVE_TH(PASSIVE_TH), .RECOV_TARGET(RECOV_TARGET)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tec_q(tec_q), .tec_raw(tec_raw),
        .rec_nxt(rec_nxt), .run_done(run_done), .state_q(st),
        .tec_clr(tec_clr), .rec_clr(rec_clr), .irq_q(irq)
    );

    // Output mapping.
    assign tec_o        = tec_q;
    assign rec_o        = rec_q;
    assign state_o      = st;
    assign busoff_irq_o = irq;
    assign tx_delay_o   = (st == FC_PASSIVE);

    // R5: error-active implies both tallies below the threshold.
    a_r5_active_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00) |-> (tec_o < TH_W && rec_o < TH_W));

    // R8: the interrupt is a single-cycle pulse.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq_o |=> !busoff_irq_o);

    // R8: entry into bus-off shows a cleared transmit tally.
    a_r8_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq_o |-> (tec_o == '0));

    // R7: a passive acknowledge error alone leaves the transmit tally.
    a_r7_passive_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && ack_err_i && !tx_err_i && !tx_ok_i) |=> $stable(tec_o));

    // R11: the receive tally is frozen while in bus-off (or zeroed on exit).
    a_r11_busoff_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |=> (rec_o == $past(rec_o) || rec_o == '0));

    // R10: leaving bus-off lands with both tallies zero.
    a_r10_exit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && tx_err_i == tx_err_i) |=> (state_o == 2'b10 || (tec_o == '0 && rec_o == '0)));
endmodule

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0, ack_err_i = 0;
    logic bit_tick_i = 0, bit_val_i = 1;
    logic [7:0] tec_o, rec_o;
    logic [1:0] state_o;
    logic busoff_irq_o, tx_delay_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fault_conf u0 (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
        .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .ack_err_i(ack_err_i),
        .bit_tick_i(bit_tick_i), .bit_val_i(bit_val_i), .tec_o(tec_o),
        .rec_o(rec_o), .state_o(state_o), .busoff_irq_o(busoff_irq_o),
        .tx_delay_o(tx_delay_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk = n_chk + 1;
        if (act != exp_v) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // One clock with the given strobes; outputs sampled just after the edge.
    task automatic step(input logic txe, input logic rxe, input logic txo,
                        input logic rxo, input logic acke, input logic tick,
                        input logic bv);
        @(negedge clk);
        tx_err_i = txe; rx_err_i = rxe; tx_ok_i = txo; rx_ok_i = rxo;
        ack_err_i = acke; bit_tick_i = tick; bit_val_i = bv;
        @(posedge clk);
        #1;
        tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0;
        ack_err_i = 0; bit_tick_i = 0; bit_val_i = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 tec", tec_o, 0);
        chk("R1 rec", rec_o, 0);
        chk("R1 state", state_o, 0);
        chk("R1 irq", busoff_irq_o, 0);
        // drive into passive, then reset mid-run
        for (int i = 0; i < 16; i++) step(1,1,0,0,0,0,1);
        chk("R1 pre-reset state", state_o, 1);
        do_reset();
        #1;
        chk("R1 tec after mid reset", tec_o, 0);
        chk("R1 rec after mid reset", rec_o, 0);
        chk("R1 state after mid reset", state_o, 0);
    endtask

    task automatic t_tx_arith();
        do_reset();
        step(0,0,1,0,0,0,1);
        chk("R2 floor at zero", tec_o, 0);
        for (int i = 0; i < 3; i++) step(1,0,0,0,0,0,1);
        chk("R2 three tx errors", tec_o, 24);
        step(0,0,1,0,0,0,1);
        chk("R2 tx success", tec_o, 23);
        step(0,0,0,0,1,0,1);
        chk("R2 active ack error", tec_o, 31);
        step(1,0,1,0,0,0,1);
        chk("R2 error beats success", tec_o, 39);
        chk("R2 still active", state_o, 0);
        chk("R5 no delay when active", tx_delay_o, 0);
    endtask

    task automatic t_rx_arith();
        do_reset();
        for (int i = 0; i < 5; i++) step(0,1,0,0,0,0,1);
        chk("R3 five rx errors", rec_o, 5);
        step(0,1,0,1,0,0,1);
        chk("R3 error beats success", rec_o, 6);
        for (int i = 0; i < 6; i++) step(0,0,0,1,0,0,1);
        chk("R3 decrement to zero", rec_o, 0);
        step(0,0,0,1,0,0,1);
        chk("R3 floor at zero", rec_o, 0);
        for (int i = 0; i < 128; i++) step(0,1,0,0,0,0,1);
        chk("R3 reaches 128", rec_o, 128);
        chk("R5 rx threshold to passive", state_o, 1);
        chk("R5 delay when passive", tx_delay_o, 1);
        for (int i = 0; i < 3; i++) step(0,1,0,0,0,0,1);
        chk("R3 saturates at 128", rec_o, 128);
        step(0,0,0,1,0,0,1);
        chk("R4 reload 119", rec_o, 119);
        chk("R6 back to active", state_o, 0);
        chk("R6 delay drops", tx_delay_o, 0);
    endtask

    task automatic t_passive_exit();
        do_reset();
        for (int i = 0; i < 16; i++) step(1,0,0,0,0,0,1);
        chk("R5 tx threshold 128", tec_o, 128);
        chk("R5 tx threshold to passive", state_o, 1);
        for (int i = 0; i < 128; i++) step(0,1,0,0,0,0,1);
        step(0,0,1,0,0,0,1);
        chk("R6 tec 127", tec_o, 127);
        chk("R6 stays passive while rec high", state_o, 1);
        step(0,0,0,1,0,0,1);
        chk("R6 exit when both low", state_o, 0);
    endtask

    task automatic t_lone_ack();
        do_reset();
        for (int i = 0; i < 20; i++) step(0,0,0,0,1,0,1);
        chk("R7 ack settles 128", tec_o, 128);
        for (int i = 0; i < 200; i++) step(0,0,0,0,1,0,1);
        chk("R7 still 128", tec_o, 128);
        chk("R7 never bus-off", state_o, 1);
    endtask

    task automatic t_busoff();
        do_reset();
        for (int i = 0; i < 10; i++) step(0,1,0,0,0,0,1);
        for (int i = 0; i < 31; i++) step(1,0,0,0,0,0,1);
        chk("R8 pre bus-off tec", tec_o, 248);
        chk("R8 pre bus-off passive", state_o, 1);
        step(1,0,0,0,0,0,1);
        chk("R8 bus-off state", state_o, 2);
        chk("R8 tec cleared", tec_o, 0);
        chk("R8 irq high", busoff_irq_o, 1);
        chk("R8 rec kept", rec_o, 10);
        step(0,0,0,0,0,0,1);
        chk("R8 irq single pulse", busoff_irq_o, 0);
        step(1,0,0,0,0,0,1);
        step(0,1,0,0,0,0,1);
        step(0,0,1,0,0,0,1);
        step(0,0,0,1,0,0,1);
        step(0,0,0,0,1,0,1);
        chk("R11 tec ignores strobes", tec_o, 0);
        chk("R11 rec ignores strobes", rec_o, 10);
        chk("R11 stays bus-off", state_o, 2);
    endtask

    task automatic t_recovery();
        for (int i = 0; i < 10; i++) step(0,0,0,0,0,1,1);
        chk("R9 ten recessive no step", tec_o, 0);
        step(0,0,0,0,0,1,0);
        for (int i = 0; i < 10; i++) step(0,0,0,0,0,1,1);
        chk("R9 dominant restarts run", tec_o, 0);
        step(0,0,0,0,0,0,1);
        chk("R9 no tick no count", tec_o, 0);
        step(0,0,0,0,0,1,1);
        chk("R9 first run completes", tec_o, 1);
        for (int r = 0; r < 126; r++)
            for (int i = 0; i < 11; i++) step(0,0,0,0,0,1,1);
        chk("R9 127 runs", tec_o, 127);
        chk("R9 still bus-off", state_o, 2);
        for (int i = 0; i < 10; i++) step(0,0,0,0,0,1,1);
        chk("R10 not yet out", state_o, 2);
        step(0,0,0,0,0,1,1);
        chk("R10 back active", state_o, 0);
        chk("R10 tec zero", tec_o, 0);
        chk("R10 rec zero", rec_o, 0);
    endtask

    initial begin
        t_reset();
        t_tx_arith();
        t_rx_arith();
        t_passive_exit();
        t_lone_ack();
        t_busoff();
        t_recovery();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule